// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block collects interrupt requests from a set of peripheral sources. It decides which one the CPU sequencer should service next. Each source is built either as an event type or as a level type, selected by a parameter mask.

- **Event-type sources** latch their request into a sticky pending flag.
- **Level-type sources** are looked at directly.

A source competes only when its own enable bit is set. The winner must also pass a global enable, a short hold-off window and the CPU status strobes. When it passes, the block raises a take strobe together with a vector number.

The sequencer accepts by pulsing an acknowledge. That acknowledge does three things: it clears the winner's pending flag, it drops the global enable, and it starts an entry timer. The timer models the cycles spent pushing the return address, plus extra cycles when the core was asleep. At the end of that time the block gives a one-cycle fetch pulse carrying the latched vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the global enable, all pending flags, `take_o` and `fetch_o` are 0.
- R2: Among enabled requesting sources the lowest source index wins; `vec_o` equals source index plus 1, vector 0 being reserved for reset and never issued.
- R3: `take_o` is raised only when the winning source's bit in `en_i` and the global enable are both 1.
- R4: An accepted acknowledge (`ack_i` while `take_o`) clears the global enable; `sei_i` or `reti_i` sets it; `cli_i` clears it. Priority is `cli_i`, then acknowledge, then set.
- R5: For an event-type source (mask bit 1), `req_i` high sets its `flags_o` bit. The bit clears on an accepted acknowledge of that source, or when a 1 is written to its `flag_clr_i` bit. A set in the same cycle wins over a clear.
- R6: A pending flag that arrives while locally or globally disabled stays pending and is taken once enabled.
- R7: A level-type source (mask bit 0; sources 2 and 5 by default) never sets its `flags_o` bit and requests only while `req_i` is high.
- R8: After an `sei_i` or `reti_i` cycle, `take_o` stays low until a `retire_i` pulse in a later cycle.
- R9: `cli_i` forces `take_o` low in the same cycle.
- R10: `busy_i` (multi-cycle instruction in progress) forces `take_o` low.
- R11: With `sleep_i` low at the accepted acknowledge, `fetch_o` is high for exactly one cycle, starting at the fourth rising edge after the acknowledge edge. With `sleep_i` high it starts at the eighth. Until then `take_o` stays low, and `vec_o` shows the latched vector while the pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request lines (event pulse or level) |
| en_i | input | N_SRC | Per-source enables |
| flag_clr_i | input | N_SRC | Write-one-to-clear for pending flags |
| sei_i | input | 1 | Set-global-enable event |
| cli_i | input | 1 | Clear-global-enable event |
| reti_i | input | 1 | Return-from-interrupt event |
| retire_i | input | 1 | Instruction retired |
| busy_i | input | 1 | Multi-cycle instruction in progress |
| sleep_i | input | 1 | Core in sleep |
| ack_i | input | 1 | Sequencer accepts offered interrupt |
| take_o | output | 1 | Interrupt offered |
| vec_o | output | VEC_W | Vector number (winner, or latched during entry) |
| fetch_o | output | 1 | Vector fetch pulse at end of entry |
| gie_o | output | 1 | Global enable state |
| flags_o | output | N_SRC | Pending flags |

## Verification
The assertions assume that the CPU strobes behave like a real core's:
- `ack_i` is only meaningful while `take_o` is high.
- `sei_i`, `reti_i` and `retire_i` are single-cycle pulses.
- `flag_clr_i` is a one-cycle write.

The stimulus changes inputs only on falling edges and holds every strobe for exactly one cycle. It raises `ack_i` only after observing `take_o` high. It leaves the entry timer to finish before starting the next scenario.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    ENT_IDLE = 1'b0,
    ENT_PUSH = 1'b1
  } ent_state_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned N_SRC = 10,
  parameter logic [N_SRC-1:0] FLAG_MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] pend_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (FLAG_MASK[i]) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       flag_q <= 1'b0;
        else if (req_i[i])                 flag_q <= 1'b1;
        else if (clr_i[i] || ack_clr_i[i]) flag_q <= 1'b0;
      end
      assign flag_o[i] = flag_q;
      assign pend_o[i] = flag_q;

      assert_ack_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_clr_i[i] && !req_i[i]) |=> !flag_q);
      assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q && !clr_i[i] && !ack_clr_i[i]) |=> flag_q);
    end else begin : g_level
      assign flag_o[i] = 1'b0;
      assign pend_o[i] = req_i[i];
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC = 10,
  localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] act_i,
  output logic             any_o,
  output logic [SRC_W-1:0] sel_o,
  output logic [N_SRC-1:0] grant_o
);
  always_comb begin
    sel_o   = '0;
    grant_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        sel_o   = SRC_W'(i);
        grant_o = N_SRC'(1) << i;
      end
    end
  end
  assign any_o = |act_i;
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sei_i,
  input  logic cli_i,
  input  logic reti_i,
  input  logic retire_i,
  input  logic busy_i,
  input  logic entry_busy_i,
  input  logic fire_i,
  output logic gie_o,
  output logic take_ok_o
);
  logic gie_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (cli_i)                gie_q <= 1'b0;
      else if (fire_i)          gie_q <= 1'b0;
      else if (sei_i || reti_i) gie_q <= 1'b1;
      if (sei_i || reti_i)      hold_q <= 1'b1;
      else if (retire_i)        hold_q <= 1'b0;
    end
  end

  assign gie_o     = gie_q;
  assign take_ok_o = gie_q & ~hold_q & ~cli_i & ~busy_i & ~entry_busy_i;

  assert_cli_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cli_i |=> !gie_q);
  assert_ack_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !gie_q);
  assert_hold_after_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sei_i || reti_i) |=> !take_ok_o);
endmodule

// File: rtl/irq_entry_timer.sv
module irq_entry_timer
  import irq_pkg::*;
#(
  parameter int unsigned VEC_W     = 4,
  parameter int unsigned PUSH_CYC  = 4,
  parameter int unsigned WAKE_CYC  = 4,
  localparam int unsigned CNT_W    = $clog2(PUSH_CYC + WAKE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sleep_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             busy_o,
  output logic             fetch_o,
  output logic [VEC_W-1:0] vec_o
);
  ent_state_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ENT_IDLE;
      cnt_q <= '0;
      vec_q <= '0;
    end else if (start_i) begin
      st_q  <= ENT_PUSH;
      cnt_q <= sleep_i ? CNT_W'(PUSH_CYC + WAKE_CYC) : CNT_W'(PUSH_CYC);
      vec_q <= vec_i;
    end else if (st_q == ENT_PUSH) begin
      if (cnt_q == '0) st_q <= ENT_IDLE;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o  = (st_q == ENT_PUSH);
  assign fetch_o = (st_q == ENT_PUSH) && (cnt_q == '0);
  assign vec_o   = vec_q;

  assert_fetch_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o);
  assert_no_early_fetch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !fetch_o);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned N_SRC = 10,
  parameter logic [N_SRC-1:0] FLAG_MASK = 10'b11_1101_1011,
  parameter int unsigned PUSH_CYC = 4,
  parameter int unsigned WAKE_CYC = 4,
  localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned VEC_W = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] flag_clr_i,
  input  logic             sei_i,
  input  logic             cli_i,
  input  logic             reti_i,
  input  logic             retire_i,
  input  logic             busy_i,
  input  logic             sleep_i,
  input  logic             ack_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             fetch_o,
  output logic             gie_o,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] pend, grant, ack_clr;
  logic [SRC_W-1:0] sel;
  logic [VEC_W-1:0] win_vec, ent_vec;
  logic any, take_ok, fire, ent_busy;

  assign fire    = ack_i & take_o;
  assign ack_clr = fire ? grant : '0;

  irq_flags #(.N_SRC(N_SRC), .FLAG_MASK(FLAG_MASK)) u_flags (
    .clk_i, .rst_ni, .req_i, .clr_i(flag_clr_i), .ack_clr_i(ack_clr),
    .flag_o(flags_o), .pend_o(pend)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .act_i(pend & en_i), .any_o(any), .sel_o(sel), .grant_o(grant)
  );

  irq_gate u_gate (
    .clk_i, .rst_ni, .sei_i, .cli_i, .reti_i, .retire_i, .busy_i,
    .entry_busy_i(ent_busy), .fire_i(fire), .gie_o, .take_ok_o(take_ok)
  );

  assign win_vec = VEC_W'(sel) + VEC_W'(1);

  irq_entry_timer #(.VEC_W(VEC_W), .PUSH_CYC(PUSH_CYC), .WAKE_CYC(WAKE_CYC)) u_ent (
    .clk_i, .rst_ni, .start_i(fire), .sleep_i, .vec_i(win_vec),
    .busy_o(ent_busy), .fetch_o, .vec_o(ent_vec)
  );

  assign take_o = any & take_ok;
  assign vec_o  = ent_busy ? ent_vec : win_vec;

  assert_take_not_in_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> !take_o);
  assert_vec_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (vec_o != '0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  localparam int N = 10;
  logic clk_i = 0, rst_ni = 0;
  logic [N-1:0] req_i = '0, en_i = '0, flag_clr_i = '0;
  logic sei_i = 0, cli_i = 0, reti_i = 0, retire_i = 0, busy_i = 0, sleep_i = 0, ack_i = 0;
  logic take_o, fetch_o, gie_o;
  logic [3:0] vec_o;
  logic [N-1:0] flags_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_prio_ctrl u_dut (.*);

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic global_on();
    cyc(); sei_i = 1; cyc(); sei_i = 0; retire_i = 1; cyc(); retire_i = 0; #1;
  endtask

  task automatic clean();
    cyc(); req_i = '0; en_i = '0; cli_i = 1; flag_clr_i = '1;
    cyc(); cli_i = 0; flag_clr_i = '0;
    repeat (10) cyc();
  endtask

  task automatic t_reset();
    #1;
    check("R1 gie", gie_o, 0); check("R1 flags", flags_o, 0);
    check("R1 take", take_o, 0); check("R1 fetch", fetch_o, 0);
  endtask

  task automatic t_priority_entry();
    en_i = '1; global_on();
    cyc(); req_i = 10'h012; cyc(); req_i = '0; #1;
    check("R2 take", take_o, 1); check("R2 vec", vec_o, 2); check("R5 set", flags_o, 10'h012);
    ack_i = 1; cyc(); ack_i = 0; #1;
    check("R4 ack clears gie", gie_o, 0); check("R5 ack clears", flags_o, 10'h010);
    check("R11 take low in entry", take_o, 0); check("R11 fetch early", fetch_o, 0);
    repeat (3) begin cyc(); #1; check("R11 fetch early", fetch_o, 0); end
    cyc(); #1; check("R11 fetch at 4", fetch_o, 1); check("R11 latched vec", vec_o, 2);
    cyc(); #1; check("R11 single pulse", fetch_o, 0);
    reti_i = 1; cyc(); reti_i = 0; #1;
    check("R4 reti sets gie", gie_o, 1); check("R8 hold after reti", take_o, 0);
    retire_i = 1; cyc(); retire_i = 0; #1;
    check("R8 take after retire", take_o, 1); check("R2 next vec", vec_o, 5);
    sleep_i = 1; ack_i = 1; cyc(); ack_i = 0; sleep_i = 0; #1;
    check("R11 sleep early", fetch_o, 0);
    repeat (7) begin cyc(); #1; check("R11 sleep early", fetch_o, 0); end
    cyc(); #1; check("R11 fetch at 8", fetch_o, 1); check("R11 sleep vec", vec_o, 5);
    clean();
  endtask

  task automatic t_global_remember();
    en_i = '1; cyc(); req_i = 10'h080; cyc(); req_i = '0; #1;
    check("R3 no gie no take", take_o, 0); check("R6 kept", flags_o, 10'h080);
    sei_i = 1; cyc(); sei_i = 0; #1; check("R8 hold after sei", take_o, 0);
    retire_i = 1; cyc(); retire_i = 0; #1;
    check("R6 served", take_o, 1); check("R6 vec", vec_o, 8);
    clean();
  endtask

  task automatic t_cli_same();
    en_i = '1; global_on(); cyc(); req_i = 10'h008; cyc(); req_i = '0; #1;
    check("R9 pre", take_o, 1);
    cli_i = 1; #1; check("R9 cli same cycle", take_o, 0);
    cyc(); cli_i = 0; #1; check("R4 cli clears gie", gie_o, 0); check("R9 after", take_o, 0);
    clean();
  endtask

  task automatic t_busy();
    en_i = '1; global_on(); cyc(); req_i = 10'h001; cyc(); req_i = '0;
    busy_i = 1; #1; check("R10 busy blocks", take_o, 0);
    cyc(); busy_i = 0; #1; check("R10 released", take_o, 1); check("R2 vec1", vec_o, 1);
    clean();
  endtask

  task automatic t_local_enable();
    en_i = '1; en_i[6] = 0; global_on(); cyc(); req_i = 10'h040; cyc(); req_i = '0; #1;
    check("R3 local disabled", take_o, 0); check("R6 flag kept", flags_o, 10'h040);
    cyc(); en_i[6] = 1; #1; check("R6 taken", take_o, 1); check("R6 vec7", vec_o, 7);
    clean();
  endtask

  task automatic t_level();
    en_i = '1; en_i[2] = 0; global_on(); cyc(); req_i[2] = 1; cyc(); cyc(); #1;
    check("R7 no flag", flags_o, 0); check("R3 level disabled", take_o, 0);
    req_i[2] = 0; cyc(); en_i[2] = 1; #1; check("R7 gone not taken", take_o, 0);
    req_i[2] = 1; #1; check("R7 level take", take_o, 1); check("R7 vec3", vec_o, 3);
    cyc(); req_i[2] = 0; #1; check("R7 drops", take_o, 0);
    clean();
  endtask

  task automatic t_w1c();
    cyc(); req_i[8] = 1; cyc(); req_i = '0; #1; check("R5 set", flags_o, 10'h100);
    flag_clr_i[8] = 1; cyc(); flag_clr_i = '0; #1; check("R5 w1c", flags_o, 0);
    req_i[8] = 1; flag_clr_i[8] = 1; cyc(); req_i = '0; flag_clr_i = '0; #1;
    check("R5 set wins", flags_o, 10'h100);
    clean();
  endtask

  initial begin
    repeat (3) cyc(); t_reset();
    cyc(); rst_ni = 1; t_reset();
    t_priority_entry();
    t_global_remember();
    t_cli_same();
    t_busy();
    t_local_enable();
    t_level();
    t_w1c();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule